// File: doc/BRIEF.md
# Page-Table Group Search Engine

When a translation lookaside buffer misses, this block walks one group of a hashed page table in memory and looks for the entry that maps a requested virtual page. Software or a miss handler supplies four values: the table's base address, a mask that selects how many hash bits index the table, a hash value and the virtual page tag. The table is a power of two in size and is aligned to its own size. A group is 64 bytes and holds eight entries of 8 bytes each.

The block forms the group's byte address. It reads each entry as two 32-bit words through a simple request/valid read port and compares each entry against the tag. It stops at the first entry that matches. The result is a one-cycle `found` pulse, carrying the entry's two words and its slot number, or a one-cycle `notFound` pulse after the eighth entry.

Computing the hash, retrying with a secondary hash and updating usage bits in the entry are left to the surrounding logic.

Top module: `pte_group_walker`

## Requirements
- R1: After reset, `busy`, `memReq`, `found` and `notFound` are all low.
- R2: The group address is `tableBase | ((hashVal & sizeMask) << 6)`. Entry k (k = 0..7) is read at two addresses. Its upper word is at group + 8k and its lower word at group + 8k + 4. Every read address is word aligned.
- R3: `memReq` stays high with a stable `memAddr` until `memValid` is sampled high. Each cycle with both `memReq` and `memValid` high transfers exactly one word on `memData`.
- R4: Entries are read in ascending slot order, upper word before lower word.
- R5: An entry matches when bit 31 of its upper word is 1 and bits [TAG_W-1:0] of that word equal `vpnTag`. An entry whose tag field matches but whose bit 31 is 0 does not match.
- R6: At the first matching entry the search ends with no further reads. `found` is then high for exactly one cycle. In that cycle `hitIndex` gives the slot, and `entryHi`/`entryLo` give the entry's upper and lower words.
- R7: If none of the eight entries matches, all 16 words are read. `notFound` is then high for exactly one cycle, and `found` stays low.
- R8: A `startReq` while `busy` is high is ignored: the search in progress continues at its own group addresses and gives its own result. `busy` goes high the cycle after an accepted start and falls in the cycle the result pulse appears.
- R9: `tableBase`, `sizeMask`, `hashVal` and `vpnTag` are sampled only when a start is accepted. Later changes to them do not affect the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Starts a search when idle |
| tableBase | input | ADDR_W | Page table base byte address |
| sizeMask | input | HASH_W | Mask applied to the hash |
| hashVal | input | HASH_W | Hash selecting the group |
| vpnTag | input | TAG_W | Virtual page tag to match |
| busy | output | 1 | Search in progress |
| memReq | output | 1 | Read request |
| memAddr | output | ADDR_W | Read byte address |
| memValid | input | 1 | Read data valid; completes the request |
| memData | input | 32 | Read data word |
| found | output | 1 | One-cycle hit pulse |
| notFound | output | 1 | One-cycle miss pulse |
| hitIndex | output | 3 | Slot of the matching entry |
| entryHi | output | 32 | Upper word of the matching entry |
| entryLo | output | 32 | Lower word of the matching entry |

## Verification
The bench places a match in every slot and also runs a full miss, each at read latencies from zero to two cycles. For every search it counts the words read and checks each address. A design that failed to stop at the first match, or that dropped the lower word, would show a wrong read count. A design that mis-shifted the hash would read the wrong group address.

Decoy entries carry the right tag but a cleared valid bit, and some groups hold two matches; a design that ignored the valid bit or kept scanning would report the wrong slot. Some searches change the inputs or raise `startReq` mid-search. A design that re-sampled the inputs or restarted would jump to a different group.

A sweep over hash and mask values checks the group address formula.

// File: rtl/pte_walk_pkg.sv
package pte_walk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_HI = 2'd1,
    ST_RD_LO = 2'd2,
    ST_CHECK = 2'd3
  } walkState_t;

  typedef struct packed {
    logic loadStart;
    logic capHi;
    logic capLo;
    logic nextEntry;
    logic setFound;
    logic setMiss;
    logic selLo;
  } walkStrobes_t;
endpackage

// File: rtl/pte_walk_ctrl.sv
module pte_walk_ctrl
  import pte_walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         memValid,
  input  logic         tagMatch,
  input  logic         lastEntry,
  output logic         busy,
  output logic         memReq,
  output walkStrobes_t strobes
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    memReq    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobes.loadStart = 1'b1;
          stateNext = ST_RD_HI;
        end
      end
      ST_RD_HI: begin
        memReq = 1'b1;
        if (memValid) begin
          strobes.capHi = 1'b1;
          stateNext = ST_RD_LO;
        end
      end
      ST_RD_LO: begin
        memReq = 1'b1;
        strobes.selLo = 1'b1;
        if (memValid) begin
          strobes.capLo = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (tagMatch) begin
          strobes.setFound = 1'b1;
          stateNext = ST_IDLE;
        end else if (lastEntry) begin
          strobes.setMiss = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobes.nextEntry = 1'b1;
          stateNext = ST_RD_HI;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pte_walk_dp.sv
module pte_walk_dp
  import pte_walk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HASH_W  = 19,
  parameter int TAG_W   = 24,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobes_t      strobes,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [HASH_W-1:0] sizeMask,
  input  logic [HASH_W-1:0] hashVal,
  input  logic [TAG_W-1:0]  vpnTag,
  input  logic [31:0]       memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              tagMatch,
  output logic              lastEntry,
  output logic              found,
  output logic              notFound,
  output logic [$clog2(ENTRIES)-1:0] hitIndex,
  output logic [31:0]       entryHi,
  output logic [31:0]       entryLo
);
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int ENTRY_SHIFT = 3;
  localparam int GROUP_SHIFT = IDX_W + ENTRY_SHIFT;
  localparam int PAD_W       = ADDR_W - HASH_W - GROUP_SHIFT;

  logic [ADDR_W-1:0] groupAddr;
  logic [ADDR_W-1:0] groupNext;
  logic [TAG_W-1:0]  tagReg;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       workHi, workLo;
  logic [ADDR_W-1:0] entryOff;

  assign groupNext = tableBase |
                     {{PAD_W{1'b0}}, (hashVal & sizeMask), {GROUP_SHIFT{1'b0}}};

  assign entryOff = {{(ADDR_W-GROUP_SHIFT){1'b0}}, idx, strobes.selLo, 2'b00};
  assign memAddr  = groupAddr | entryOff;

  assign tagMatch  = workHi[31] && (workHi[TAG_W-1:0] == tagReg);
  assign lastEntry = (idx == IDX_W'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupAddr <= '0;
      tagReg    <= '0;
      idx       <= '0;
      workHi    <= '0;
      workLo    <= '0;
    end else begin
      if (strobes.loadStart) begin
        groupAddr <= groupNext;
        tagReg    <= vpnTag;
        idx       <= '0;
      end else if (strobes.nextEntry) begin
        idx <= idx + 1'b1;
      end
      if (strobes.capHi) workHi <= memData;
      if (strobes.capLo) workLo <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      found    <= 1'b0;
      notFound <= 1'b0;
      hitIndex <= '0;
      entryHi  <= '0;
      entryLo  <= '0;
    end else begin
      found    <= strobes.setFound;
      notFound <= strobes.setMiss;
      if (strobes.setFound) begin
        hitIndex <= idx;
        entryHi  <= workHi;
        entryLo  <= workLo;
      end
    end
  end
endmodule

// File: rtl/pte_group_walker.sv
module pte_group_walker
  import pte_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HASH_W = 19,
  parameter int TAG_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [HASH_W-1:0] sizeMask,
  input  logic [HASH_W-1:0] hashVal,
  input  logic [TAG_W-1:0]  vpnTag,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [31:0]       memData,
  output logic              found,
  output logic              notFound,
  output logic [2:0]        hitIndex,
  output logic [31:0]       entryHi,
  output logic [31:0]       entryLo
);
  walkStrobes_t strobes;
  logic tagMatch, lastEntry;

  pte_walk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .memValid  (memValid),
    .tagMatch  (tagMatch),
    .lastEntry (lastEntry),
    .busy      (busy),
    .memReq    (memReq),
    .strobes   (strobes)
  );

  pte_walk_dp #(
    .ADDR_W  (ADDR_W),
    .HASH_W  (HASH_W),
    .TAG_W   (TAG_W),
    .ENTRIES (8)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .tableBase (tableBase),
    .sizeMask  (sizeMask),
    .hashVal   (hashVal),
    .vpnTag    (vpnTag),
    .memData   (memData),
    .memAddr   (memAddr),
    .tagMatch  (tagMatch),
    .lastEntry (lastEntry),
    .found     (found),
    .notFound  (notFound),
    .hitIndex  (hitIndex),
    .entryHi   (entryHi),
    .entryLo   (entryLo)
  );
endmodule

// File: rtl/pte_group_walker_chk.sv
module pte_group_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              found,
  input logic              notFound
);
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  a_r3_req_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  a_r6_found_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    found |=> !found);

  a_r7_miss_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    notFound |=> !notFound);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(found && notFound));

  a_r8_done_with_result: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (found || notFound));
endmodule

bind pte_group_walker pte_group_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .memReq   (memReq),
  .memValid (memValid),
  .memAddr  (memAddr),
  .found    (found),
  .notFound (notFound)
);

// File: tb/pte_group_walker_tb.sv
module pte_group_walker_tb;
  localparam int ADDR_W = 32;
  localparam int HASH_W = 19;
  localparam int TAG_W  = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [ADDR_W-1:0] tableBase = '0;
  logic [HASH_W-1:0] sizeMask = '0;
  logic [HASH_W-1:0] hashVal = '0;
  logic [TAG_W-1:0]  vpnTag = '0;
  logic              busy, memReq, found, notFound;
  logic [ADDR_W-1:0] memAddr;
  logic              memValid = 1'b0;
  logic [31:0]       memData = '0;
  logic [2:0]        hitIndex;
  logic [31:0]       entryHi, entryLo;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit reported = 0;

  logic [31:0] hiMem [8];
  logic [31:0] loMem [8];
  logic [ADDR_W-1:0] expGrp;
  int readCount;
  int latency;

  always #4 clk = ~clk;

  pte_group_walker #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tableBase(tableBase),
    .sizeMask(sizeMask), .hashVal(hashVal), .vpnTag(vpnTag), .busy(busy),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .found(found), .notFound(notFound), .hitIndex(hitIndex),
    .entryHi(entryHi), .entryLo(entryLo)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] grpOf(input logic [ADDR_W-1:0] b,
      input logic [HASH_W-1:0] m, input logic [HASH_W-1:0] h);
    logic [ADDR_W-1:0] hx;
    hx = ADDR_W'(h & m);
    return b | (hx << 6);
  endfunction

  // memory responder with programmable latency; checks every address (R2, R4)
  initial begin
    int cnt;
    logic [ADDR_W-1:0] want;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (memValid) begin
        memValid = 1'b0;
        cnt = 0;
      end else if (memReq) begin
        if (cnt >= latency) begin
          want = expGrp + ADDR_W'((readCount / 2) * 8 + (readCount % 2) * 4);
          chk(memAddr == want, "R2 R4 read address", 64'(memAddr), 64'(want));
          memData  = memAddr[2] ? loMem[memAddr[5:3]] : hiMem[memAddr[5:3]];
          memValid = 1'b1;
          readCount++;
        end else cnt++;
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !reported) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        reported = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  // fill the group: entry p matches (p==8: none); decoy invalid entry with right tag
  task automatic fillGroup(input logic [TAG_W-1:0] tag, input int p, input int second);
    for (int i = 0; i < 8; i++) begin
      hiMem[i] = {1'b1, 7'd0, tag ^ TAG_W'(i + 1)};
      loMem[i] = 32'hC0DE_0000 | (i << 8) | (tag[7:0]);
    end
    if (p < 8) hiMem[p] = {1'b1, 7'h11, tag};
    if (p > 0) hiMem[p - 1] = {1'b0, 7'h22, tag};
    if (second < 8) hiMem[second] = {1'b1, 7'h33, tag};
  endtask

  task automatic runSearch(input logic [ADDR_W-1:0] b, input logic [HASH_W-1:0] m,
      input logic [HASH_W-1:0] h, input logic [TAG_W-1:0] tag, input int p,
      input bit disturb);
    int waitCnt;
    expGrp = grpOf(b, m, h);
    readCount = 0;
    @(negedge clk);
    tableBase = b; sizeMask = m; hashVal = h; vpnTag = tag;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    if (disturb) begin
      // R9: change inputs; R8: start while busy
      tableBase = ~b; hashVal = ~h; vpnTag = ~tag;
      @(negedge clk);
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    waitCnt = 0;
    while (!(found || notFound) && waitCnt < 500) begin
      @(negedge clk);
      waitCnt++;
    end
    if (p < 8) begin
      chk(found && !notFound, "R6 found pulse", 64'({found, notFound}), 64'h2);
      chk(hitIndex == 3'(p), "R6 hitIndex", 64'(hitIndex), 64'(p));
      chk(entryHi == hiMem[p], "R5 R6 entryHi", 64'(entryHi), 64'(hiMem[p]));
      chk(entryLo == loMem[p], "R6 entryLo", 64'(entryLo), 64'(loMem[p]));
      chk(readCount == 2 * (p + 1), "R6 stop at first match", 64'(readCount), 64'(2 * (p + 1)));
    end else begin
      chk(notFound && !found, "R7 notFound pulse", 64'({found, notFound}), 64'h1);
      chk(readCount == 16, "R7 all words read", 64'(readCount), 64'd16);
    end
    chk(busy == 1'b0, "R8 busy low at result", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!found && !notFound, "R6 R7 one-cycle pulse", 64'({found, notFound}), 64'd0);
    chk(memReq == 1'b0, "R3 no request when idle", 64'(memReq), 64'd0);
  endtask

  initial begin
    latency = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !memReq && !found && !notFound, "R1 reset state",
        64'({busy, memReq, found, notFound}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq && !found && !notFound, "R1 idle after reset",
        64'({busy, memReq, found, notFound}), 64'd0);

    // R4 R5 R6 R7: every match slot and a miss, at three latencies (R3)
    for (int lat = 0; lat < 3; lat++) begin
      latency = lat;
      for (int p = 0; p <= 8; p++) begin
        fillGroup(24'h5A5000 + TAG_W'(p * 17 + lat), p, 8);
        runSearch(32'h0010_0000, 19'h000FF, 19'(p * 37 + lat), 24'h5A5000 + TAG_W'(p * 17 + lat), p, 0);
      end
    end

    // R6: two matches, first one wins
    latency = 1;
    fillGroup(24'h123456, 2, 6);
    runSearch(32'h0400_0000, 19'h0FFFF, 19'h1234, 24'h123456, 2, 0);

    // R8 R9: disturbed searches
    fillGroup(24'hABCDEF, 5, 8);
    runSearch(32'h0200_0000, 19'h003FF, 19'h2AA, 24'hABCDEF, 5, 1);
    fillGroup(24'h00BEEF, 8, 8);
    runSearch(32'h0200_0000, 19'h003FF, 19'h155, 24'h00BEEF, 8, 1);

    // R2: group address sweep over hashes and masks
    latency = 0;
    for (int mk = 0; mk < 3; mk++) begin
      for (int h = 0; h < 16; h++) begin
        logic [HASH_W-1:0] mv;
        mv = (mk == 0) ? 19'h00003 : (mk == 1) ? 19'h0000F : 19'h7FFFF;
        fillGroup(24'h010203 + TAG_W'(h), 0, 8);
        runSearch(32'h8000_0000 >> mk, mv, 19'(h * 4099 + 3), 24'h010203 + TAG_W'(h), 0, 0);
      end
    end

    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end
endmodule